// File: doc/BRIEF.md
# I2C Target Address Match Unit

This block decides whether the first byte received after a START or repeated START on an I2C target interface selects this target. A byte deserializer hands it the byte with the 7-bit address in bits 7:1 and the R/W bit in bit 0, together with a one-cycle strobe. The unit compares the address either against four independent address registers, or, in masked mode, against two of them (entries 0 and 2), each with its own mask.

When an address selects the target, the unit marks the target active, records the transfer direction, marks the last byte as an address and raises the address flag. It stores the received byte either in a dedicated address buffer or in the data receive buffer, which also raises the receive-full status and the receive flag. When configured to hold on address, it also asks for a clock stretch and raises the general interrupt flag, so software can inspect the address before the bus moves on. Software releases the stretch and acknowledges the flags through single-cycle clear strobes.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: After reset all status outputs (tgt_active, rd_info, data_flag, adr_if, gen_if, stretch, rx_full, rx_if) are 0 and both buffers read 0.
- R2: With cfg_masked = 0, a byte whose bits 7:1 equal any one of the four entries of cfg_adr selects the target.
- R3: With cfg_masked = 1, only cfg_adr entry 0 (with cfg_mask entry 0) and entry 2 (with cfg_mask entry 1) take part; a mask bit of 1 leaves that address bit out of the comparison, and entries 1 and 3 never select the target.
- R4: On a selecting byte, tgt_active becomes 1, rd_info takes byte bit 0 (1 = read), data_flag becomes 0 and adr_if becomes 1, all one clock after the strobe.
- R5: On a selecting byte with cfg_hold_en = 1 and cfg_stretch_dis = 0, stretch and gen_if also become 1; otherwise both keep their value. sw_stretch_clr clears stretch; sw_irq_ack clears adr_if and gen_if.
- R6: With cfg_abd = 0 the selecting byte is written to addr_buf, and rx_buf, rx_full and rx_if keep their values.
- R7: With cfg_abd = 1 the selecting byte is written to rx_buf and rx_full and rx_if become 1, while addr_buf keeps its value.
- R8: sw_rxb_read or sw_clr_buf clears both rx_full and rx_if.
- R9: A byte that selects no entry changes no status output and no buffer.
- R10: Only the first byte_vld after a start_det is compared; later strobes are ignored until the next start_det, and stop_det clears tgt_active.
- R11: data_byte while tgt_active is 1 sets data_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | START or repeated START seen (one cycle) |
| stop_det | input | 1 | STOP seen (one cycle) |
| byte_vld | input | 1 | Received byte strobe (one cycle) |
| byte_data | input | ADR_W+1 | Received byte: address in 7:1, R/W in 0 |
| data_byte | input | 1 | Data path reports a data byte (one cycle) |
| cfg_masked | input | 1 | 1 = masked comparison mode |
| cfg_adr | input | NUM_ADR x ADR_W | Address registers |
| cfg_mask | input | NUM_ADR/2 x ADR_W | Masks for entries 0 and 2 |
| cfg_hold_en | input | 1 | Hold the bus after an address match |
| cfg_stretch_dis | input | 1 | Clock stretching disabled |
| cfg_abd | input | 1 | 1 = route address to receive buffer |
| sw_stretch_clr | input | 1 | Software releases the stretch |
| sw_irq_ack | input | 1 | Software clears adr_if and gen_if |
| sw_rxb_read | input | 1 | Software reads the receive buffer |
| sw_clr_buf | input | 1 | Software clear-buffer command |
| tgt_active | output | 1 | Target selected |
| rd_info | output | 1 | Direction of the selected transfer |
| data_flag | output | 1 | Last byte was data (0 = address) |
| adr_if | output | 1 | Address match flag |
| gen_if | output | 1 | General interrupt flag |
| stretch | output | 1 | Clock-stretch request |
| rx_full | output | 1 | Receive buffer full |
| rx_if | output | 1 | Receive interrupt flag |
| addr_buf | output | ADR_W+1 | Address buffer |
| rx_buf | output | ADR_W+1 | Receive buffer |

## Verification
A wrong comparison shows up one clock after the strobe as tgt_active and adr_if staying low for a valid address or rising for a foreign one, with the buffer contents moving or failing to move. A broken arming state shows as a repeated byte in the same transfer overwriting addr_buf or rd_info, visible at the very next clock. Misrouting or wrong flag side effects appear in the same cycle as a buffer changing on the wrong side, or rx_full, stretch or gen_if taking the wrong value, and stay visible until software clears them.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic {
        ROUTE_ADB = 1'b0,
        ROUTE_RXB = 1'b1
    } route_e;

    localparam int AM_DEF_ADR_W   = 7;
    localparam int AM_DEF_NUM_ADR = 4;

endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
    parameter int ADR_W = 7
) (
    input  logic [ADR_W-1:0] rx_adr,
    input  logic [ADR_W-1:0] ref_adr,
    input  logic [ADR_W-1:0] ign_mask,
    input  logic             enable,
    output logic             eq
);
    logic [ADR_W-1:0] diff;

    always_comb begin
        diff = (rx_adr ^ ref_adr) & ~ign_mask;
        eq   = enable && (diff == '0);
    end
endmodule

// File: rtl/i2c_am_match.sv
module i2c_am_match #(
    parameter int ADR_W   = 7,
    parameter int NUM_ADR = 4,
    localparam int NUM_MASK = NUM_ADR / 2
) (
    input  logic [ADR_W-1:0]                rx_adr,
    input  logic                            masked,
    input  logic [NUM_ADR-1:0][ADR_W-1:0]   adr_tab,
    input  logic [NUM_MASK-1:0][ADR_W-1:0]  mask_tab,
    output logic [NUM_ADR-1:0]              hit_vec,
    output logic                            hit
);
    for (genvar i = 0; i < NUM_ADR; i++) begin : g_ent
        if (i % 2 == 0) begin : g_pair
            logic [ADR_W-1:0] msk;
            assign msk = masked ? mask_tab[i/2] : '0;
            i2c_am_cmp #(.ADR_W(ADR_W)) u_cmp (
                .rx_adr  (rx_adr),
                .ref_adr (adr_tab[i]),
                .ign_mask(msk),
                .enable  (1'b1),
                .eq      (hit_vec[i])
            );
        end else begin : g_plain
            i2c_am_cmp #(.ADR_W(ADR_W)) u_cmp (
                .rx_adr  (rx_adr),
                .ref_adr (adr_tab[i]),
                .ign_mask('0),
                .enable  (!masked),
                .eq      (hit_vec[i])
            );
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
    import i2c_am_pkg::*;
#(
    parameter int ADR_W   = AM_DEF_ADR_W,
    parameter int NUM_ADR = AM_DEF_NUM_ADR,
    localparam int BW       = ADR_W + 1,
    localparam int NUM_MASK = NUM_ADR / 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_det,
    input  logic                           stop_det,
    input  logic                           byte_vld,
    input  logic [BW-1:0]                  byte_data,
    input  logic                           data_byte,
    input  logic                           cfg_masked,
    input  logic [NUM_ADR-1:0][ADR_W-1:0]  cfg_adr,
    input  logic [NUM_MASK-1:0][ADR_W-1:0] cfg_mask,
    input  logic                           cfg_hold_en,
    input  logic                           cfg_stretch_dis,
    input  logic                           cfg_abd,
    input  logic                           sw_stretch_clr,
    input  logic                           sw_irq_ack,
    input  logic                           sw_rxb_read,
    input  logic                           sw_clr_buf,
    output logic                           tgt_active,
    output logic                           rd_info,
    output logic                           data_flag,
    output logic                           adr_if,
    output logic                           gen_if,
    output logic                           stretch,
    output logic                           rx_full,
    output logic                           rx_if,
    output logic [BW-1:0]                  addr_buf,
    output logic [BW-1:0]                  rx_buf
);
    typedef struct packed {
        logic          armed;
        logic          active;
        logic          rd;
        logic          data;
        logic          adr_if;
        logic          gen_if;
        logic          stretch;
        logic          rx_full;
        logic          rx_if;
        logic [BW-1:0] adb;
        logic [BW-1:0] rxb;
    } am_state_t;

    am_state_t st_d, st_q;
    logic [NUM_ADR-1:0] hit_vec;
    logic hit;
    logic match_evt;
    route_e route;

    i2c_am_match #(.ADR_W(ADR_W), .NUM_ADR(NUM_ADR)) u_match (
        .rx_adr  (byte_data[BW-1:1]),
        .masked  (cfg_masked),
        .adr_tab (cfg_adr),
        .mask_tab(cfg_mask),
        .hit_vec (hit_vec),
        .hit     (hit)
    );

    always_comb begin
        st_d      = st_q;
        route     = cfg_abd ? ROUTE_RXB : ROUTE_ADB;
        match_evt = byte_vld && st_q.armed && hit;

        if (byte_vld)  st_d.armed = 1'b0;
        if (start_det) st_d.armed = 1'b1;
        if (stop_det)  st_d.active = 1'b0;
        if (data_byte && st_q.active) st_d.data = 1'b1;
        if (sw_stretch_clr) st_d.stretch = 1'b0;
        if (sw_irq_ack) begin
            st_d.adr_if = 1'b0;
            st_d.gen_if = 1'b0;
        end
        if (sw_rxb_read || sw_clr_buf) begin
            st_d.rx_full = 1'b0;
            st_d.rx_if   = 1'b0;
        end

        if (match_evt) begin
            st_d.active = 1'b1;
            st_d.rd     = byte_data[0];
            st_d.data   = 1'b0;
            st_d.adr_if = 1'b1;
            if (cfg_hold_en && !cfg_stretch_dis) begin
                st_d.stretch = 1'b1;
                st_d.gen_if  = 1'b1;
            end
            if (route == ROUTE_RXB) begin
                st_d.rxb     = byte_data;
                st_d.rx_full = 1'b1;
                st_d.rx_if   = 1'b1;
            end else begin
                st_d.adb = byte_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgt_active = st_q.active;
    assign rd_info    = st_q.rd;
    assign data_flag  = st_q.data;
    assign adr_if     = st_q.adr_if;
    assign gen_if     = st_q.gen_if;
    assign stretch    = st_q.stretch;
    assign rx_full    = st_q.rx_full;
    assign rx_if      = st_q.rx_if;
    assign addr_buf   = st_q.adb;
    assign rx_buf     = st_q.rxb;

    assert_sel_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> (tgt_active && adr_if && !data_flag && rd_info == $past(byte_data[0])));

    assert_stretch_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stretch) |-> (adr_if && gen_if));

    assert_adb_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !cfg_abd) |=> (addr_buf == $past(byte_data)));

    assert_rx_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && cfg_abd) |=> (rx_full && rx_if && rx_buf == $past(byte_data)));

    assert_no_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !hit && !stop_det && !data_byte && !sw_stretch_clr &&
         !sw_irq_ack && !sw_rxb_read && !sw_clr_buf)
        |=> ($stable(tgt_active) && $stable(adr_if) && $stable(addr_buf) &&
             $stable(rx_buf) && $stable(rd_info)));
endmodule

// File: tb/i2c_tgt_addr_match_test.sv
module i2c_tgt_addr_match_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_det = 0, stop_det = 0, byte_vld = 0, data_byte = 0;
    logic [7:0] byte_data = '0;
    logic cfg_masked = 0, cfg_hold_en = 0, cfg_stretch_dis = 0, cfg_abd = 0;
    logic [3:0][6:0] cfg_adr;
    logic [1:0][6:0] cfg_mask;
    logic sw_stretch_clr = 0, sw_irq_ack = 0, sw_rxb_read = 0, sw_clr_buf = 0;
    logic tgt_active, rd_info, data_flag, adr_if, gen_if, stretch, rx_full, rx_if;
    logic [7:0] addr_buf, rx_buf;
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_tgt_addr_match uut (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .byte_vld(byte_vld), .byte_data(byte_data), .data_byte(data_byte),
        .cfg_masked(cfg_masked), .cfg_adr(cfg_adr), .cfg_mask(cfg_mask),
        .cfg_hold_en(cfg_hold_en), .cfg_stretch_dis(cfg_stretch_dis), .cfg_abd(cfg_abd),
        .sw_stretch_clr(sw_stretch_clr), .sw_irq_ack(sw_irq_ack),
        .sw_rxb_read(sw_rxb_read), .sw_clr_buf(sw_clr_buf),
        .tgt_active(tgt_active), .rd_info(rd_info), .data_flag(data_flag),
        .adr_if(adr_if), .gen_if(gen_if), .stretch(stretch), .rx_full(rx_full),
        .rx_if(rx_if), .addr_buf(addr_buf), .rx_buf(rx_buf)
    );

    function automatic logic [7:0] st(input bit a, r, d, ai, gi, s, f, ri);
        return {a, r, d, ai, gi, s, f, ri};
    endfunction

    function automatic logic [7:0] cur();
        return {tgt_active, rd_info, data_flag, adr_if, gen_if, stretch, rx_full, rx_if};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clean();
        @(negedge clk);
        stop_det = 1; sw_irq_ack = 1; sw_stretch_clr = 1; sw_clr_buf = 1;
        @(negedge clk);
        stop_det = 0; sw_irq_ack = 0; sw_stretch_clr = 0; sw_clr_buf = 0;
    endtask

    task automatic do_start();
        @(negedge clk); start_det = 1;
        @(negedge clk); start_det = 0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_vld = 1; byte_data = b;
        @(negedge clk); byte_vld = 0;
    endtask

    task automatic t_reset();
        chk("R1 status", cur(), 8'h00);
        chk("R1 addr_buf", addr_buf, 8'h00);
        chk("R1 rx_buf", rx_buf, 8'h00);
    endtask

    task automatic t_unmasked();
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b;
            b = {cfg_adr[i], 1'(i % 2)};
            clean(); do_start(); send(b);
            chk("R2 R4 status", cur(), st(1, 1'(i % 2), 0, 1, 0, 0, 0, 0));
            chk("R6 addr_buf", addr_buf, b);
            chk("R6 rx_buf untouched", rx_buf, 8'h00);
        end
        clean();
        chk("R10 stop clears active", cur(), st(0, 1, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_mismatch();
        clean(); do_start(); send({7'h7F, 1'b0});
        chk("R9 status unchanged", cur(), st(0, 1, 0, 0, 0, 0, 0, 0));
        chk("R9 addr_buf unchanged", addr_buf, {7'h3A, 1'b1});
    endtask

    task automatic t_masked();
        cfg_masked = 1; cfg_mask[0] = 7'h03; cfg_mask[1] = 7'h00;
        clean(); do_start(); send({7'h13, 1'b0});
        chk("R3 masked entry0 match", cur(), st(1, 0, 0, 1, 0, 0, 0, 0));
        clean(); do_start(); send({7'h22, 1'b1});
        chk("R3 entry1 excluded", cur(), st(0, 0, 0, 0, 0, 0, 0, 0));
        clean(); do_start(); send({7'h51, 1'b1});
        chk("R3 entry2 match", cur(), st(1, 1, 0, 1, 0, 0, 0, 0));
        clean(); do_start(); send({7'h50, 1'b0});
        chk("R3 entry2 unmasked bit", cur(), st(0, 1, 0, 0, 0, 0, 0, 0));
        cfg_masked = 0;
    endtask

    task automatic t_hold();
        cfg_hold_en = 1; cfg_stretch_dis = 0;
        clean(); do_start(); send({7'h10, 1'b0});
        chk("R5 hold sets stretch", cur(), st(1, 0, 0, 1, 1, 1, 0, 0));
        @(negedge clk); sw_stretch_clr = 1; @(negedge clk); sw_stretch_clr = 0;
        chk("R5 stretch release", cur(), st(1, 0, 0, 1, 1, 0, 0, 0));
        @(negedge clk); sw_irq_ack = 1; @(negedge clk); sw_irq_ack = 0;
        chk("R5 irq ack", cur(), st(1, 0, 0, 0, 0, 0, 0, 0));
        cfg_stretch_dis = 1;
        clean(); do_start(); send({7'h10, 1'b1});
        chk("R5 stretch disabled", cur(), st(1, 1, 0, 1, 0, 0, 0, 0));
        cfg_hold_en = 0; cfg_stretch_dis = 0;
    endtask

    task automatic t_abd();
        cfg_abd = 1;
        clean(); do_start(); send({7'h22, 1'b0});
        chk("R7 rx flags", cur(), st(1, 0, 0, 1, 0, 0, 1, 1));
        chk("R7 rx_buf", rx_buf, 8'h44);
        chk("R7 addr_buf kept", addr_buf, 8'h21);
        @(negedge clk); sw_rxb_read = 1; @(negedge clk); sw_rxb_read = 0;
        chk("R8 read clears", cur(), st(1, 0, 0, 1, 0, 0, 0, 0));
        clean(); do_start(); send({7'h51, 1'b1});
        chk("R7 second route", cur(), st(1, 1, 0, 1, 0, 0, 1, 1));
        @(negedge clk); sw_clr_buf = 1; @(negedge clk); sw_clr_buf = 0;
        chk("R8 clear buffer", cur(), st(1, 1, 0, 1, 0, 0, 0, 0));
        chk("R7 rx_buf kept", rx_buf, 8'hA3);
        cfg_abd = 0;
    endtask

    task automatic t_armed();
        clean(); do_start(); send({7'h10, 1'b0});
        chk("R10 first byte", addr_buf, 8'h20);
        send({7'h22, 1'b1});
        chk("R10 later byte ignored buf", addr_buf, 8'h20);
        chk("R10 later byte ignored status", cur(), st(1, 0, 0, 1, 0, 0, 0, 0));
        @(negedge clk); data_byte = 1; @(negedge clk); data_byte = 0;
        chk("R11 data flag", cur(), st(1, 0, 1, 1, 0, 0, 0, 0));
        do_start(); send({7'h3A, 1'b1});
        chk("R4 restart clears data", cur(), st(1, 1, 0, 1, 0, 0, 0, 0));
        chk("R10 restart rearms", addr_buf, 8'h75);
    endtask

    initial begin
        cfg_adr[0] = 7'h10; cfg_adr[1] = 7'h22; cfg_adr[2] = 7'h51; cfg_adr[3] = 7'h3A;
        cfg_mask[0] = '0; cfg_mask[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_unmasked();
        t_mismatch();
        t_masked();
        t_hold();
        t_abd();
        t_armed();
        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule